// File: doc/BRIEF.md
# Real-Time Clock with Alarm Interrupt

This block keeps time of day as four cascaded counters: a 256-step sub-second count, seconds, minutes and hours. A 256 Hz tick enable from a slow timebase drives the counters, and a run enable starts or stops them. Software uses a register-style port to load the time, program four alarm values and choose which alarm fields take part in matching.

When a tick advances the time, the new time is compared with the alarm values on every enabled field. A full match sets a sticky interrupt flag, but only while the interrupt enable is high. The choice of enabled fields sets the alarm period:

- sub-second alone gives once per second;
- sub-second and seconds give once per minute;
- sub-second, seconds and minutes give once per hour;
- all four give once per day.

With no field enabled, every advancing tick raises the flag. Software clears the flag with a clear pulse.

Top module: `rtc_alarm_top`

## Requirements
- R1: After a synchronous active-low reset, all time fields, all alarm registers and the match-enable register read 0, and `irq` is 0.
- R2: On each cycle with `tick_256` and `run_en` high and no time write, the sub-second field (address 0) increments. It wraps from 255 to 0 and carries into seconds on that same tick.
- R3: Seconds (address 1) and minutes (address 2) wrap from 59 to 0, and hours (address 3) wraps from 23 to 0. All carries ripple on the same tick, so 23:59:59.255 becomes 00:00:00.000 in one step.
- R4: While `run_en` is low, no time field changes, whatever `tick_256` does.
- R5: A write to addresses 0 to 3 loads the field at that clock edge. The sub-second field keeps 8 bits, seconds and minutes keep 6 bits, and hours keeps 5 bits. A tick in the same cycle is dropped, so no field advances.
- R6: Addresses 4 to 7 hold the alarm values for sub-second, seconds, minutes and hours, in that order. Address 8 bits [3:0] are the match enables for the same four fields, bit 0 being sub-second. `rd_data` returns all of these combinationally. All other addresses read 0.
- R7: When an advancing tick makes every enabled field equal its alarm value and `irq_en` is high, `irq` is 1 from the same clock edge that updates the time.
- R8: With all match enables 0 and `irq_en` high, every advancing tick sets `irq`.
- R9: With sub-second and seconds matching enabled and both alarms 0, exactly one flag event occurs while the time crosses a minute boundary.
- R10: `irq` stays set until a cycle with `irq_clr` high and no new match. It is then 0 after that edge. If a clear and a match fall in the same cycle, the flag stays set.
- R11: A time write never sets `irq` in its own cycle, even if the written value equals the alarm.
- R12: While `irq_en` is low, no match sets `irq`, and a flag that is already set is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_256 | input | 1 | One-cycle enable at 256 Hz |
| run_en | input | 1 | Timekeeping run control |
| irq_en | input | 1 | Alarm interrupt enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Combinational read data |
| irq_clr | input | 1 | Flag clear pulse |
| irq | output | 1 | Sticky alarm interrupt flag |

## Verification
Two pairs of events can fall in the same cycle.

- **Write and tick.** A time write can coincide with a tick. The bench provokes this directly by writing a field that equals the alarm during a tick, and also by chance in the random phase. It then expects the written value to read back unchanged and `irq` to stay low.
- **Clear and match.** A software clear can coincide with a new match. The bench forces a clear on every tick while no field is enabled, and the flag must remain high.

All other outcomes are judged against a cycle-level reference model in the bench, built from the requirements.

// File: rtl/rtc_alarm_pkg.sv
// Shared constants for the alarm clock: field count, register address
// layout, and per-field width and wrap limit.
package rtc_alarm_pkg;
    localparam int NFIELD = 4;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;
    localparam logic [ADDR_W-1:0] ADR_TIME0  = 4'd0;
    localparam logic [ADDR_W-1:0] ADR_ALARM0 = ADR_TIME0 + ADDR_W'(NFIELD);
    localparam logic [ADDR_W-1:0] ADR_MEN    = ADR_ALARM0 + ADDR_W'(NFIELD);

    // Stored width of field i (0 = sub-second ... 3 = hours).
    function automatic int field_width(input int i);
        case (i)
            0:       return 8;
            1, 2:    return 6;
            default: return 5;
        endcase
    endfunction

    // Last legal value of field i before it wraps to zero.
    function automatic int field_last(input int i);
        case (i)
            0:       return 255;
            1, 2:    return 59;
            default: return 23;
        endcase
    endfunction
endpackage

// File: rtl/rtc_field_cnt.sv
// One time field: a wrapping counter with a synchronous load.
// The load has priority over the increment. Values at or above LAST
// wrap to zero on the next increment.
module rtc_field_cnt #(
    parameter int W    = 8,
    parameter int LAST = 255
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] val,
    output logic [W-1:0] nxt
);
    logic at_last;

    // Detect the wrap point.
    assign at_last = (val >= W'(LAST));

    // Next value: load first, then increment with wrap.
    always_comb begin
        if (load)
            nxt = load_val;
        else if (inc)
            nxt = at_last ? '0 : val + W'(1);
        else
            nxt = val;
    end

    // Field register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            val <= '0;
        else
            val <= nxt;
    end
endmodule

// File: rtl/rtc_alarm_cmp.sv
// Alarm comparator. A field matches when its enable is low or when its
// next time value equals the alarm value. The hit output is the AND of
// all fields. It assumes that all values are zero-extended to DW bits.
module rtc_alarm_cmp #(
    parameter int N  = 4,
    parameter int DW = 8
) (
    input  logic [DW-1:0] t_nxt [N],
    input  logic [DW-1:0] alarm [N],
    input  logic [N-1:0]  en,
    output logic          hit
);
    logic [N-1:0] fld_ok;

    for (genvar g = 0; g < N; g++) begin : g_eq
        // Per-field match, or don't-care when disabled.
        assign fld_ok[g] = !en[g] || (t_nxt[g] == alarm[g]);
    end

    assign hit = &fld_ok;
endmodule

// File: rtl/rtc_irq_flag.sv
// Sticky interrupt flag. Set has priority over clear.
module rtc_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Flag register: set wins, clear otherwise, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end
endmodule

// File: rtl/rtc_alarm_top.sv
// Time-of-day counter with a programmable alarm.
//
// Four cascaded fields (sub-second, seconds, minutes, hours) advance on
// tick_256 while run_en is high. Writes to the time registers load at
// once and drop a tick in the same cycle. The next time value is compared
// with the alarm registers under per-field enables, so the flag rises on
// the same edge that the matching time appears.
//
// Assumes tick_256 is a single-cycle pulse in the clk domain.
module rtc_alarm_top
    import rtc_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_256,
    input  logic              run_en,
    input  logic              irq_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              irq_clr,
    output logic              irq
);
    logic              time_wr;
    logic              step;
    logic [NFIELD-1:0] inc;
    logic [DATA_W-1:0] t_val [NFIELD];
    logic [DATA_W-1:0] t_nxt [NFIELD];
    logic [DATA_W-1:0] al_q  [NFIELD];
    logic [NFIELD-1:0] men_q;
    logic              hit;

    // A write to any time field suppresses the tick.
    assign time_wr = wr_en && (wr_addr < ADR_ALARM0);
    assign step    = tick_256 && run_en && !time_wr;
    assign inc[0]  = step;

    for (genvar g = 0; g < NFIELD; g++) begin : g_fld
        localparam int W = field_width(g);
        localparam int L = field_last(g);
        logic [W-1:0] q;
        logic [W-1:0] n;

        rtc_field_cnt #(.W(W), .LAST(L)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (time_wr && (wr_addr == ADR_TIME0 + ADDR_W'(g))),
            .load_val (wr_data[W-1:0]),
            .inc      (inc[g]),
            .val      (q),
            .nxt      (n)
        );

        assign t_val[g] = DATA_W'(q);
        assign t_nxt[g] = DATA_W'(n);

        // Carry into the next field when this one wraps.
        if (g < NFIELD - 1) begin : g_carry
            assign inc[g+1] = inc[g] && (q >= W'(L));
        end

        // Alarm value register for this field.
        always_ff @(posedge clk) begin
            if (!rst_n)
                al_q[g] <= '0;
            else if (wr_en && (wr_addr == ADR_ALARM0 + ADDR_W'(g)))
                al_q[g] <= wr_data;
        end
    end

    // Match-enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            men_q <= '0;
        else if (wr_en && (wr_addr == ADR_MEN))
            men_q <= wr_data[NFIELD-1:0];
    end

    rtc_alarm_cmp #(.N(NFIELD), .DW(DATA_W)) u_cmp (
        .t_nxt (t_nxt),
        .alarm (al_q),
        .en    (men_q),
        .hit   (hit)
    );

    rtc_irq_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (step && hit && irq_en),
        .clr   (irq_clr),
        .flag  (irq)
    );

    // Combinational read-back mux.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NFIELD; i++) begin
            if (rd_addr == ADR_TIME0 + ADDR_W'(i))
                rd_data = t_val[i];
            if (rd_addr == ADR_ALARM0 + ADDR_W'(i))
                rd_data = al_q[i];
        end
        if (rd_addr == ADR_MEN)
            rd_data = DATA_W'(men_q);
    end
endmodule

// File: rtl/rtc_alarm_chk.sv
// Protocol checker for rtc_alarm_top, attached by bind.
module rtc_alarm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_256,
    input logic       run_en,
    input logic       irq_en,
    input logic       wr_en,
    input logic [3:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       irq_clr,
    input logic       irq,
    input logic [7:0] t_sub,
    input logic [7:0] t_sec,
    input logic [7:0] t_min,
    input logic [7:0] t_hr
);
    logic twr;
    assign twr = wr_en && (wr_addr < 4'd4);

    // R4
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !wr_en) |=> ($stable(t_sub) && $stable(t_sec) && $stable(t_min) && $stable(t_hr)));

    // R3
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_256 && run_en && !twr && t_sub == 8'd255 && t_sec == 8'd59) |=> (t_sec == 8'd0));

    // R5
    sec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 4'd1) |=> (t_sec == {2'b00, $past(wr_data[5:0])}));

    // R10
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    // R10
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !tick_256) |=> !irq);

    // R11
    no_match_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && twr) |=> !irq);

    // R12
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !irq_en) |=> !irq);
endmodule

bind rtc_alarm_top rtc_alarm_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_256 (tick_256),
    .run_en   (run_en),
    .irq_en   (irq_en),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .irq_clr  (irq_clr),
    .irq      (irq),
    .t_sub    (t_val[0]),
    .t_sec    (t_val[1]),
    .t_min    (t_val[2]),
    .t_hr     (t_val[3])
);

// File: tb/tb_rtc_alarm_top.sv
`timescale 1ns/1ps
module tb_rtc_alarm_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_256 = 1'b0, run_en = 1'b0, irq_en = 1'b0;
    logic       wr_en = 1'b0, irq_clr = 1'b0;
    logic [3:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq;

    int errs = 0, checks = 0;
    bit done = 0;

    int m_t[4], m_al[4], m_en, m_flag;
    int LASTV[4] = '{255, 59, 59, 23};
    int MASKV[4] = '{255, 63, 63, 31};

    always #2.5 clk = ~clk;

    rtc_alarm_top dut (.*);

    // Expected read-back value from the reference model.
    function automatic int rd_exp(input int a);
        if (a < 4) return m_t[a];
        if (a < 8) return m_al[a-4];
        if (a == 8) return m_en;
        return 0;
    endfunction

    // Next-state model, written from the requirements.
    task automatic model_step(input bit tk, input bit we, input int wa, input int wd, input bit clr);
        int nt[4];
        bit twr, stp, hit, carry;
        nt = m_t;
        twr = we && wa < 4;
        stp = tk && run_en && !twr;
        if (twr) nt[wa] = wd & MASKV[wa];
        if (stp) begin
            carry = 1;
            for (int i = 0; i < 4; i++) begin
                if (carry) begin
                    if (m_t[i] >= LASTV[i]) nt[i] = 0;
                    else begin nt[i] = m_t[i] + 1; carry = 0; end
                end
            end
        end
        hit = 1;
        for (int i = 0; i < 4; i++)
            if (m_en[i] && nt[i] != m_al[i]) hit = 0;
        if (stp && hit && irq_en) m_flag = 1;
        else if (clr) m_flag = 0;
        if (we && wa >= 4 && wa < 8) m_al[wa-4] = wd;
        if (we && wa == 8) m_en = wd & 15;
        m_t = nt;
    endtask

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, model at posedge, compare at next negedge.
    task automatic cyc(input bit tk, input bit we, input int wa, input int wd,
                       input bit clr, input int ra, input string tag);
        tick_256 = tk; wr_en = we; wr_addr = 4'(wa); wr_data = 8'(wd);
        irq_clr = clr; rd_addr = 4'(ra);
        @(posedge clk);
        model_step(tk, we, wa, wd, clr);
        @(negedge clk);
        check(tag, "irq", int'(irq), m_flag);
        check(tag, "rd_data", int'(rd_data), rd_exp(ra));
        tick_256 = 0; wr_en = 0; irq_clr = 0;
    endtask

    task automatic wr(input int a, input int d, input string tag);
        cyc(0, 1, a, d, 0, a, tag);
    endtask

    task automatic set_time(input int h, input int mi, input int s, input int sub, input string tag);
        wr(3, h, tag); wr(2, mi, tag); wr(1, s, tag); wr(0, sub, tag);
    endtask

    int cnt;

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_t = '{0, 0, 0, 0}; m_al = '{0, 0, 0, 0}; m_en = 0; m_flag = 0;

        // R1: reset state
        for (int a = 0; a < 10; a++) begin
            rd_addr = 4'(a); #0.1;
            check("R1", "rd_data", int'(rd_data), 0);
        end
        check("R1", "irq", int'(irq), 0);

        // R2: sub-second counts and wraps into seconds
        run_en = 1;
        for (int k = 0; k < 3; k++) cyc(1, 0, 0, 0, 0, 0, "R2");
        check("R2", "sub", int'(rd_data), 3);
        wr(0, 255, "R2");
        cyc(1, 0, 0, 0, 0, 1, "R2");
        check("R2", "sec after wrap", int'(rd_data), 1);

        // R3: full day rollover
        set_time(23, 59, 59, 255, "R3");
        cyc(1, 0, 0, 0, 0, 3, "R3");
        check("R3", "hours after rollover", int'(rd_data), 0);
        for (int a = 0; a < 3; a++) cyc(0, 0, 0, 0, 0, a, "R3");

        // R4: stopped clock ignores ticks
        run_en = 0;
        for (int k = 0; k < 5; k++) cyc(1, 0, 0, 0, 0, 0, "R4");
        check("R4", "sub held", int'(rd_data), 0);
        run_en = 1;

        // R6: alarm and enable readback; unused address
        for (int a = 4; a < 9; a++) wr(a, 8'h05 + a, "R6");
        cyc(0, 0, 0, 0, 0, 9, "R6");
        wr(8, 0, "R6");

        // R8 + R10: no enables, every tick sets, and a clear on the same cycle loses
        irq_en = 1;
        for (int k = 0; k < 6; k++) begin
            cyc(1, 0, 0, 0, 1, 0, "R8");
            check("R10", "set beats clear", int'(irq), 1);
        end
        cyc(0, 0, 0, 0, 1, 0, "R10");
        check("R10", "cleared", int'(irq), 0);

        // R5 + R11: time write during a tick, value equals alarm
        wr(4, 40, "R11"); wr(8, 1, "R11");
        cyc(1, 1, 0, 40, 0, 0, "R11");
        check("R11", "no irq on write", int'(irq), 0);
        check("R5", "loaded value kept", int'(rd_data), 40);
        cyc(1, 1, 1, 8'hFF, 0, 1, "R5");
        check("R5", "sec masked", int'(rd_data), 63);

        // R7: hour alarm
        wr(7, 5, "R7"); wr(8, 4'b1000, "R7");
        set_time(4, 59, 59, 255, "R7");
        cyc(1, 0, 0, 0, 0, 3, "R7");
        check("R7", "irq on hour match", int'(irq), 1);
        cyc(0, 0, 0, 0, 1, 0, "R7");

        // R12: gated interrupt, held flag
        irq_en = 0;
        wr(8, 0, "R12");
        cyc(1, 0, 0, 0, 0, 0, "R12");
        check("R12", "no set while gated", int'(irq), 0);
        irq_en = 1;
        cyc(1, 0, 0, 0, 0, 0, "R12");
        irq_en = 0;
        cyc(1, 0, 0, 0, 0, 0, "R12");
        check("R12", "held while gated", int'(irq), 1);
        irq_en = 1;
        cyc(0, 0, 0, 0, 1, 0, "R12");

        // R9: once-per-minute event count
        wr(4, 0, "R9"); wr(5, 0, "R9"); wr(8, 4'b0011, "R9");
        set_time(0, 0, 58, 250, "R9");
        cnt = 0;
        for (int k = 0; k < 600; k++) begin
            cyc(1, 0, 0, 0, 1, 2, "R9");
            if (irq) cnt++;
        end
        check("R9", "events per minute crossing", cnt, 1);

        // Random phase against the model (R2..R12)
        for (int k = 0; k < 6000; k++) begin
            int wa, wd;
            bit tk, we, clr;
            tk = ($urandom % 3) == 0;
            we = ($urandom % 8) == 0;
            wa = $urandom % 10;
            wd = $urandom % 256;
            if (wa < 4) wd = wd % (LASTV[wa] + 1);
            if (wa == 8) wd = $urandom % 16;
            clr = ($urandom % 6) == 0;
            run_en = ($urandom % 10) != 0;
            irq_en = ($urandom % 8) != 0;
            cyc(tk, we, wa, wd, clr, $urandom % 11, "R7-rand");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    // Watchdog.
    initial begin
        #900000;
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog act=1 exp=0");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule